// File: doc/BRIEF.md
# Controller Role Request Sequencer

This block runs the request a standby bus controller makes when it wants to become the active controller. Software writes a one to a request bit. If the device supports the simple request procedure, the block moves to a pending state. It then watches the clock and data lines until the bus has been idle long enough. After that it asks the in-band interrupt engine to send a request frame, which carries the device's own dynamic address with a write bit.

The active controller replies in one of three ways. It can accept. It can refuse. It can refuse and then, shortly after, send a disable-events command that switches off role requests. Each reply is recorded as a distinct 3-bit status code, and every reply raises a one-cycle response interrupt. Software uses the status code to decide what to do next: retry, wait for a handoff, or re-enable requests.

Status codes: 3'b000 idle, 3'b001 pending, 3'b010 refused (a retry is allowed), 3'b011 refused and requests disabled, 3'b100 accepted (ownership will move).

Top module: `crr_sequencer`

## Requirements
- R1: After reset, `crr_status` is 3'b000, and both `ibi_req` and `rsp_irq` are 0.
- R2: A clock edge with `crr_wr`=1, `crr_wdata`=1 and `simple_crr_cap`=1 starts a request. This applies from status 000, 010 or 100, and the status becomes 001 at that edge. A write of 0, or any write while `simple_crr_cap`=0, leaves the status unchanged.
- R3: While the status is 001, writes to the request bit have no effect. The status stays 001, and the issue phase of `ibi_req` is neither restarted nor advanced.
- R4: While the status is 001, `ibi_req` rises only at the first edge after SCL and SDA have both been high for `IDLE_CYCLES` consecutive edges. Any low level restarts this count. Once high, `ibi_req` stays high until a reply arrives.
- R5: An ACK with `ibi_req` high sets the status to 100 and drops `ibi_req`. If ACK and NACK arrive in the same cycle, ACK wins.
- R6: A NACK with `ibi_req` high sets the status to 010 and drops `ibi_req`.
- R7: In status 010, a disable-events-with-role-request-bit indication seen within the `DISEC_WIN` edges that follow the NACK sets the status to 011. This takes precedence over a write in the same cycle. The same indication seen later is ignored, and the status stays 010.
- R8: `rsp_irq` is high for exactly one cycle, in the cycle after the status has entered 010, 011 or 100. It is low at all other times.
- R9: `ibi_header` equals `{own_dyn_addr, 1'b0}` while `ibi_req` is high, and all zeros otherwise.
- R10: In status 011, request writes are ignored. A `crr_reenable` pulse returns the status to 000 with no interrupt. In any other status, `crr_reenable` has no effect.
- R11: ACK, NACK and disable indications that arrive while no request frame is being issued leave the status unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| crr_wr | input | 1 | Write strobe for the request bit |
| crr_wdata | input | 1 | Value written to the request bit |
| simple_crr_cap | input | 1 | Simple role request procedure supported |
| crr_reenable | input | 1 | Software re-enables role requests after a disable |
| scl_i | input | 1 | Sampled SCL level |
| sda_i | input | 1 | Sampled SDA level |
| own_dyn_addr | input | ADDR_W | Device's own dynamic address |
| ac_ack | input | 1 | Active controller acknowledged the request frame |
| ac_nack | input | 1 | Active controller refused the request frame |
| ac_disec_cr | input | 1 | Decoded disable-events command with the role-request bit set |
| crr_status | output | 3 | Request status code |
| ibi_req | output | 1 | Ask the interrupt engine to send the request frame |
| ibi_header | output | ADDR_W+1 | Address and write bit for the frame |
| rsp_irq | output | 1 | One-cycle response interrupt |

## Verification
The hardest case to reach is the boundary of the disable window. A refusal has to be issued first, which needs a pending request and an idle bus of exactly the right length. Then the disable indication must land on the last edge inside the window, or on the first edge outside it. Directed sequences place the indication on both sides of that edge. The bus idle count is also checked one edge before and one edge after the frame request rises. Seeded random traffic, with mostly idle bus lines, then keeps driving pending requests into refusals, so that collisions of write, re-enable and disable in the same cycle are compared against a bench model cycle by cycle.

// File: rtl/crr_pkg.sv
package crr_pkg;
  typedef enum logic [2:0] {
    ST_IDLE     = 3'b000,
    ST_PENDING  = 3'b001,
    ST_RETRY    = 3'b010,
    ST_DISABLED = 3'b011,
    ST_GRANTED  = 3'b100
  } crr_state_e;

  function automatic logic is_reply_code(input logic [2:0] s);
    return (s == ST_RETRY) || (s == ST_DISABLED) || (s == ST_GRANTED);
  endfunction

  function automatic logic write_accepted(input logic [2:0] s);
    return (s == ST_IDLE) || (s == ST_RETRY) || (s == ST_GRANTED);
  endfunction
endpackage

// File: rtl/crr_bus_idle.sv
module crr_bus_idle #(
  parameter int IDLE_CYCLES = 50
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic bus_avail
);
  localparam int CW = $clog2(IDLE_CYCLES + 1);
  localparam logic [CW-1:0] LIMIT = CW'(IDLE_CYCLES);

  logic [CW-1:0] cnt_q;
  logic          lines_high;

  assign lines_high = scl_i & sda_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (!lines_high)    cnt_q <= '0;
    else if (cnt_q != LIMIT) cnt_q <= cnt_q + 1'b1;
  end

  assign bus_avail = (cnt_q == LIMIT);

  AST_LOW_LINE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    !lines_high |=> !bus_avail); // R4
endmodule

// File: rtl/crr_disec_window.sv
module crr_disec_window #(
  parameter int DISEC_WIN = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  output logic win_open
);
  localparam int CW = $clog2(DISEC_WIN + 1);
  localparam logic [CW-1:0] SPAN = CW'(DISEC_WIN);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt_q <= '0;
    else if (load)        cnt_q <= SPAN;
    else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign win_open = (cnt_q != '0);

  AST_WIN_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> win_open); // R7
endmodule

// File: rtl/crr_sequencer.sv
module crr_sequencer
  import crr_pkg::*;
#(
  parameter int ADDR_W      = 7,
  parameter int IDLE_CYCLES = 50,
  parameter int DISEC_WIN   = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              crr_wr,
  input  logic              crr_wdata,
  input  logic              simple_crr_cap,
  input  logic              crr_reenable,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic [ADDR_W-1:0] own_dyn_addr,
  input  logic              ac_ack,
  input  logic              ac_nack,
  input  logic              ac_disec_cr,
  output logic [2:0]        crr_status,
  output logic              ibi_req,
  output logic [ADDR_W:0]   ibi_header,
  output logic              rsp_irq
);
  localparam int HDR_W = ADDR_W + 1;

  crr_state_e st_q, st_d;
  logic       issued_q, issued_d;
  logic       irq_q, irq_d;

  logic bus_avail;
  logic win_open;
  logic win_load;
  logic write_req;
  logic outcome_ack;
  logic outcome_nack;
  logic disec_hit;

  crr_bus_idle #(.IDLE_CYCLES(IDLE_CYCLES)) u_idle (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i), .bus_avail(bus_avail)
  );

  crr_disec_window #(.DISEC_WIN(DISEC_WIN)) u_win (
    .clk(clk), .rst_n(rst_n), .load(win_load), .win_open(win_open)
  );

  assign write_req    = crr_wr & crr_wdata & simple_crr_cap;
  assign outcome_ack  = (st_q == ST_PENDING) & issued_q & ac_ack;
  assign outcome_nack = (st_q == ST_PENDING) & issued_q & ac_nack & ~ac_ack;
  assign disec_hit    = (st_q == ST_RETRY) & win_open & ac_disec_cr;
  assign win_load     = outcome_nack;

  always_comb begin
    st_d     = st_q;
    issued_d = issued_q;
    irq_d    = 1'b0;
    unique case (st_q)
      ST_PENDING: begin
        if (!issued_q) begin
          if (bus_avail) issued_d = 1'b1;
        end else if (outcome_ack) begin
          st_d = ST_GRANTED; issued_d = 1'b0;
        end else if (outcome_nack) begin
          st_d = ST_RETRY;   issued_d = 1'b0;
        end
      end
      ST_RETRY: begin
        if (disec_hit)      st_d = ST_DISABLED;
        else if (write_req) st_d = ST_PENDING;
      end
      ST_DISABLED: begin
        if (crr_reenable) st_d = ST_IDLE;
      end
      default: begin
        if (write_req && write_accepted(st_q)) st_d = ST_PENDING;
        else if (!write_accepted(st_q))        st_d = ST_IDLE;
      end
    endcase
    if (st_d != st_q && is_reply_code(st_d)) irq_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      issued_q <= 1'b0;
      irq_q    <= 1'b0;
    end else begin
      st_q     <= st_d;
      issued_q <= issued_d;
      irq_q    <= irq_d;
    end
  end

  assign crr_status = st_q;
  assign ibi_req    = (st_q == ST_PENDING) & issued_q;
  assign ibi_header = ibi_req ? {own_dyn_addr, 1'b0} : {HDR_W{1'b0}};
  assign rsp_irq    = irq_q;

  AST_NO_CAP_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q != ST_PENDING && !simple_crr_cap) |=> (st_q != ST_PENDING)); // R2
  AST_PENDING_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_PENDING && !issued_q) |=> (st_q == ST_PENDING)); // R3
  AST_REQ_AFTER_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ibi_req) |-> $past(bus_avail)); // R4
  AST_GRANT_NEEDS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_GRANTED && $past(st_q) != ST_GRANTED) |-> $past(ac_ack)); // R5
  AST_DISABLE_FROM_RETRY: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_DISABLED && $past(st_q) != ST_DISABLED) |-> $past(st_q) == ST_RETRY); // R7
  AST_IRQ_ON_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_irq |-> (st_q != $past(st_q))); // R8
  AST_IRQ_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_irq |-> (st_q inside {ST_RETRY, ST_DISABLED, ST_GRANTED})); // R8
  AST_DISABLED_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_DISABLED && !crr_reenable) |=> (st_q == ST_DISABLED)); // R10
  AST_NO_REPLY_UNISSUED: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_PENDING && !issued_q) |=> !rsp_irq); // R11
endmodule

// File: tb/crr_sequencer_test.sv
module crr_sequencer_test;
  localparam int AW = 7;
  localparam int NIDLE = 8;
  localparam int WIN = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr = 0, wd = 0, cap = 0, reen = 0, scl = 0, sda = 0, ack = 0, nack = 0, disec = 0;
  logic [AW-1:0] addr = 7'h2A;
  logic [2:0] status;
  logic ibi_req, irq;
  logic [AW:0] hdr;

  int n_tests = 0, n_fail = 0;
  bit done = 0;

  logic [2:0] m_st;
  bit m_iss, m_irq;
  int m_idle, m_win;

  always #10 clk = ~clk;

  crr_sequencer #(.ADDR_W(AW), .IDLE_CYCLES(NIDLE), .DISEC_WIN(WIN)) uut (
    .clk(clk), .rst_n(rst_n), .crr_wr(wr), .crr_wdata(wd), .simple_crr_cap(cap),
    .crr_reenable(reen), .scl_i(scl), .sda_i(sda), .own_dyn_addr(addr),
    .ac_ack(ack), .ac_nack(nack), .ac_disec_cr(disec),
    .crr_status(status), .ibi_req(ibi_req), .ibi_header(hdr), .rsp_irq(irq));

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic string tag_of(input logic [2:0] s);
    case (s)
      3'b001:  return "R2";
      3'b010:  return "R6";
      3'b011:  return "R7";
      3'b100:  return "R5";
      default: return "R1";
    endcase
  endfunction

  function automatic logic [AW:0] exp_hdr(input bit req, input logic [AW-1:0] a);
    return req ? {a, 1'b0} : '0;
  endfunction

  // Bench model: derived from the requirement list
  task automatic step();
    logic [2:0] n_st = m_st;
    bit n_iss = m_iss, n_irq = 0;
    int n_idle, n_win;
    bit avail = (m_idle == NIDLE);
    bit start = wr && wd && cap;
    n_idle = (scl && sda) ? ((m_idle == NIDLE) ? NIDLE : m_idle + 1) : 0;
    n_win  = (m_win > 0) ? m_win - 1 : 0;
    if (m_st == 3'b001) begin
      if (!m_iss) n_iss = avail;
      else if (ack)  begin n_st = 3'b100; n_iss = 0; n_irq = 1; end
      else if (nack) begin n_st = 3'b010; n_iss = 0; n_irq = 1; n_win = WIN; end
    end else if (m_st == 3'b010) begin
      if (disec && m_win > 0) begin n_st = 3'b011; n_irq = 1; end
      else if (start) n_st = 3'b001;
    end else if (m_st == 3'b011) begin
      if (reen) n_st = 3'b000;
    end else if (start) n_st = 3'b001;
    @(posedge clk);
    @(negedge clk);
    m_st = n_st; m_iss = n_iss; m_irq = n_irq; m_idle = n_idle; m_win = n_win;
    check(status == m_st, tag_of(m_st), status, m_st);
    check(ibi_req == (m_st == 3'b001 && m_iss), "R4", ibi_req, (m_st == 3'b001 && m_iss));
    check(hdr == exp_hdr(m_st == 3'b001 && m_iss, addr), "R9", hdr, exp_hdr(m_st == 3'b001 && m_iss, addr));
    check(irq == m_irq, "R8", irq, m_irq);
    wr = 0; wd = 0; reen = 0; ack = 0; nack = 0; disec = 0;
  endtask

  task automatic steps(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    m_st = 0; m_iss = 0; m_irq = 0; m_idle = 0; m_win = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: reset state
    check(status == 3'b000, "R1", status, 0);
    check(ibi_req == 0 && irq == 0, "R1", {ibi_req, irq}, 0);

    // R2: no capability, and a zero write, do nothing
    cap = 0; wr = 1; wd = 1; step();
    check(status == 3'b000, "R2", status, 0);
    cap = 1; wr = 1; wd = 0; step();
    check(status == 3'b000, "R2", status, 0);
    wr = 1; wd = 1; step();
    check(status == 3'b001, "R2", status, 1);

    // R3 and R11: bus busy, repeated writes and stray replies are ignored
    wr = 1; wd = 1; step();
    check(status == 3'b001 && ibi_req == 0, "R3", {status, ibi_req}, 3'b0010);
    ack = 1; step();
    nack = 1; step();
    check(status == 3'b001 && irq == 0, "R11", {status, irq}, 3'b0010);

    // R4: idle count boundary
    scl = 1; sda = 1;
    steps(NIDLE);
    check(ibi_req == 0, "R4", ibi_req, 0);
    step();
    check(ibi_req == 1, "R4", ibi_req, 1);
    check(hdr == {addr, 1'b0}, "R9", hdr, {addr, 1'b0});

    // R6, R7: refusal, then a disable that arrives one edge too late
    nack = 1; step();
    check(status == 3'b010 && irq == 1, "R6", {status, irq}, 5);
    steps(WIN);
    disec = 1; step();
    check(status == 3'b010, "R7", status, 2);

    // R7: disable on the last edge inside the window, racing a write
    wr = 1; wd = 1; step();
    step();
    nack = 1; step();
    steps(WIN - 1);
    disec = 1; wr = 1; wd = 1; step();
    check(status == 3'b011 && irq == 1, "R7", {status, irq}, 7);

    // R10: writes ignored while disabled, re-enable returns to idle
    wr = 1; wd = 1; step();
    check(status == 3'b011, "R10", status, 3);
    reen = 1; step();
    check(status == 3'b000 && irq == 0, "R10", {status, irq}, 0);
    reen = 1; step();
    check(status == 3'b000, "R10", status, 0);

    // R5: ACK beats NACK, and the interrupt lasts one cycle (R8)
    wr = 1; wd = 1; step();
    step();
    ack = 1; nack = 1; step();
    check(status == 3'b100 && irq == 1, "R5", {status, irq}, 9);
    step();
    check(irq == 0, "R8", irq, 0);

    // Seeded random traffic compared against the model
    for (int i = 0; i < 4000; i++) begin
      int r = $urandom_range(0, 99);
      scl   = ($urandom_range(0, 99) < 90);
      sda   = ($urandom_range(0, 99) < 92);
      cap   = ($urandom_range(0, 99) < 85);
      wr    = (r < 15);
      wd    = ($urandom_range(0, 99) < 80);
      reen  = ($urandom_range(0, 99) < 6);
      ack   = ($urandom_range(0, 99) < 8);
      nack  = ($urandom_range(0, 99) < 12);
      disec = ($urandom_range(0, 99) < 15);
      if ((i % 97) == 0) addr = 7'($urandom());
      step();
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule